// File: doc/BRIEF.md
# Page-list address walker

The walker turns one host transfer descriptor into an ordered run of physical memory segments. A descriptor carries a total byte length and two 64-bit pointers. The first pointer may sit anywhere inside a page and supplies the first segment. The second pointer is used in one of two ways. If the rest of the transfer fits in one page, it is itself the second segment. Otherwise it addresses a list page of 64-bit entries, and each entry names one data page. When more pages remain than one list page can hold, the last slot of that list page holds the address of the next list page.

List entries reach the block from outside. The walker sends a read request that gives a list address and an entry count. The entries then arrive on an input stream, one 64-bit word per beat. Every segment leaves on a valid/ready output. If a pointer is malformed the walk stops, and the block raises a one-cycle error pulse. A walk that finishes normally ends with a one-cycle done pulse instead.

All stream interfaces follow the usual valid/ready rules, and a transfer happens on a rising edge where both are high. A valid output stays high, with its payload unchanged, until it is accepted. Back-pressure on the segment output stalls the walker and also holds off list entries, so no entry is lost. The page size is 2^shift, where the shift is sampled when the descriptor is accepted.

Top module: `page_list_walker`

## Requirements
- R1: A descriptor with length 0 produces no segment, no read request and no error. A done pulse follows in the cycle after acceptance.
- R2: The first segment starts at pointer 1. Its length is the smaller of the total length and (page size − pointer 1 mod page size).
- R3: If the remaining length after the first segment is at most one page, the walker emits one segment at pointer 2 for the whole remainder. Pointer 2 must then be a multiple of the page size (zero is accepted here), or the walk ends in error with no second segment.
- R4: If more than one page remains, the walker issues a read request at pointer 2. The count is the smaller of ceil(remaining/page size) and the entries per list page, which is page size / 8.
- R5: Each list entry that is not a chain slot yields one segment at the entry's value. The segment length is the smaller of the remaining length and one page. Segments appear in stream order.
- R6: The entry in slot index (page size/8 − 1) of a list page is a chain pointer whenever more than one page still remains. It yields no segment. Instead a new read request goes out at its value, and slot counting restarts at 0.
- R7: A list entry (data or chain) that is zero or not a multiple of the page size ends the walk with an error pulse and no further segment. The remaining beats of the current request are still accepted and discarded.
- R8: While the segment output is valid and not ready, its address and length stay unchanged. A pending read request is held in the same way.
- R9: Done and error are single-cycle pulses and never occur together. Either one comes only after the last segment has been accepted. The descriptor input is ready only between walks, and after reset it is ready with no output valid.
- R10: The page size is 2^shift, with the shift clamped to the range MIN_SHIFT..MAX_SHIFT (4..12 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Descriptor valid |
| cmd_ready_o | output | 1 | Descriptor accepted (idle) |
| cmd_len_i | input | LEN_W | Total transfer length in bytes |
| cmd_ptr1_i | input | ADDR_W | First pointer, any byte alignment |
| cmd_ptr2_i | input | ADDR_W | Second pointer: direct page or list address |
| page_shift_i | input | SHIFT_W | log2 of page size, sampled at acceptance |
| seg_valid_o | output | 1 | Segment valid |
| seg_ready_i | input | 1 | Segment accepted |
| seg_addr_o | output | ADDR_W | Segment start address |
| seg_len_o | output | LEN_W | Segment length in bytes |
| rd_req_valid_o | output | 1 | List read request valid |
| rd_req_ready_i | input | 1 | List read request accepted |
| rd_req_addr_o | output | ADDR_W | Byte address of first requested entry |
| rd_req_cnt_o | output | CNT_W | Number of 64-bit entries requested |
| ent_valid_i | input | 1 | List entry beat valid |
| ent_ready_o | output | 1 | List entry beat accepted |
| ent_data_i | input | 64 | List entry value |
| walk_done_o | output | 1 | One-cycle pulse: walk completed |
| walk_err_o | output | 1 | One-cycle pulse: invalid field, walk aborted |

## Verification
The first segment becomes valid two rising edges after the descriptor is accepted. Each list segment becomes valid one edge after its entry is accepted. A chain entry gives a new request one edge later, and a zero-length descriptor gives its done pulse one edge after acceptance. The bench applies pseudo-random ready and valid patterns. At every falling edge it records each handshake that the coming edge will complete, so it checks the order and content of every segment and request, not a fixed cycle count. Done and error are registered. The bench samples them at the falling edge where they first appear, checks that they are low again one cycle later, and checks that every expected segment was accepted before the pulse.

// File: rtl/plw_pkg.sv
package plw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_ROUTE,
    ST_DIRECT,
    ST_REQ,
    ST_ENTRY,
    ST_DRAIN,
    ST_FLUSH
  } plw_state_e;

endpackage

// File: rtl/plw_page_calc.sv
module plw_page_calc #(
  parameter int ADDR_W    = 64,
  parameter int LEN_W     = 32,
  parameter int MIN_SHIFT = 4,
  parameter int MAX_SHIFT = 12,
  parameter int SHIFT_W   = 4,
  parameter int CNT_W     = 10
) (
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [ADDR_W-1:0]  ptr_i,
  input  logic [LEN_W-1:0]   rem_i,
  output logic [LEN_W-1:0]   first_len_o,
  output logic [LEN_W-1:0]   page_len_o,
  output logic [CNT_W-1:0]   req_cnt_o,
  output logic [CNT_W-1:0]   epp_m1_o,
  output logic               rem_gt_page_o,
  output logic               ptr_aligned_o,
  output logic               ptr_ok_o
);

  logic [SHIFT_W-1:0] sh;
  logic [LEN_W:0]     page_w, off_w, room_w, rem_x, sum_w, pages_w, epp_w, req_w;
  logic [ADDR_W-1:0]  amask;

  // clamp the page shift into the supported range (R10)
  always_comb begin
    if (shift_i < SHIFT_W'(MIN_SHIFT))      sh = SHIFT_W'(MIN_SHIFT);
    else if (shift_i > SHIFT_W'(MAX_SHIFT)) sh = SHIFT_W'(MAX_SHIFT);
    else                                    sh = shift_i;
  end

  always_comb begin
    page_w  = (LEN_W+1)'(1) << sh;
    amask   = ADDR_W'(page_w) - ADDR_W'(1);
    off_w   = (LEN_W+1)'(ptr_i & amask);
    room_w  = page_w - off_w;
    rem_x   = {1'b0, rem_i};
    sum_w   = rem_x + page_w - (LEN_W+1)'(1);
    pages_w = sum_w >> sh;
    epp_w   = page_w >> 3;
    req_w   = (pages_w < epp_w) ? pages_w : epp_w;

    first_len_o   = (rem_x < room_w) ? rem_i : LEN_W'(room_w);
    page_len_o    = (rem_x < page_w) ? rem_i : LEN_W'(page_w);
    req_cnt_o     = CNT_W'(req_w);
    epp_m1_o      = CNT_W'(epp_w - (LEN_W+1)'(1));
    rem_gt_page_o = rem_x > page_w;
    ptr_aligned_o = (ptr_i & amask) == '0;
    ptr_ok_o      = ptr_aligned_o && (ptr_i != '0);
  end

endmodule

// File: rtl/plw_seg_slot.sv
module plw_seg_slot #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              free_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o
);

  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;

  assign free_o  = !valid_q || ready_i;
  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign len_o   = len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      len_q   <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      addr_q  <= addr_i;
      len_q   <= len_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  a_r8_seg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(len_o));

  a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> free_o);

endmodule

// File: rtl/plw_list_track.sv
module plw_list_track #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             beat_i,
  output logic [CNT_W-1:0] slot_o,
  output logic [CNT_W-1:0] beats_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_o  <= '0;
      beats_o <= '0;
    end else if (load_i) begin
      slot_o  <= '0;
      beats_o <= cnt_i;
    end else if (beat_i) begin
      slot_o  <= slot_o + CNT_W'(1);
      beats_o <= beats_o - CNT_W'(1);
    end
  end

  a_r7_no_extra_beat: assert property (@(posedge clk) disable iff (!rst_n)
    beat_i |-> beats_o != '0);

  a_r6_load_alone: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !beat_i && cnt_i != '0);

endmodule

// File: rtl/page_list_walker.sv
module page_list_walker
  import plw_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int LEN_W     = 32,
  parameter int MIN_SHIFT = 4,
  parameter int MAX_SHIFT = 12,
  localparam int SHIFT_W  = $clog2(MAX_SHIFT + 1),
  localparam int CNT_W    = MAX_SHIFT - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic [LEN_W-1:0]   cmd_len_i,
  input  logic [ADDR_W-1:0]  cmd_ptr1_i,
  input  logic [ADDR_W-1:0]  cmd_ptr2_i,
  input  logic [SHIFT_W-1:0] page_shift_i,
  output logic               seg_valid_o,
  input  logic               seg_ready_i,
  output logic [ADDR_W-1:0]  seg_addr_o,
  output logic [LEN_W-1:0]   seg_len_o,
  output logic               rd_req_valid_o,
  input  logic               rd_req_ready_i,
  output logic [ADDR_W-1:0]  rd_req_addr_o,
  output logic [CNT_W-1:0]   rd_req_cnt_o,
  input  logic               ent_valid_i,
  output logic               ent_ready_o,
  input  logic [63:0]        ent_data_i,
  output logic               walk_done_o,
  output logic               walk_err_o
);

  plw_state_e         state_q, state_d;
  logic [SHIFT_W-1:0] shift_q;
  logic [LEN_W-1:0]   rem_q;
  logic [ADDR_W-1:0]  p1_q, list_q;
  logic               err_q, done_q, fail_q;

  logic [ADDR_W-1:0]  calc_ptr;
  logic [LEN_W-1:0]   c_first, c_page_len;
  logic [CNT_W-1:0]   c_req, c_epp_m1;
  logic               c_gt, c_aligned, c_ok;

  logic               seg_load, seg_free;
  logic [LEN_W-1:0]   ld_len;
  logic               trk_load, trk_beat;
  logic [CNT_W-1:0]   slot, beats;
  logic               ent_beat, is_chain, last_beat;

  // pointer under test depends on the phase of the walk
  always_comb begin
    case (state_q)
      ST_FIRST: calc_ptr = p1_q;
      ST_ENTRY: calc_ptr = ADDR_W'(ent_data_i);
      default:  calc_ptr = list_q;
    endcase
  end

  plw_page_calc #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MIN_SHIFT(MIN_SHIFT),
    .MAX_SHIFT(MAX_SHIFT), .SHIFT_W(SHIFT_W), .CNT_W(CNT_W)
  ) u_calc (
    .shift_i      (shift_q),
    .ptr_i        (calc_ptr),
    .rem_i        (rem_q),
    .first_len_o  (c_first),
    .page_len_o   (c_page_len),
    .req_cnt_o    (c_req),
    .epp_m1_o     (c_epp_m1),
    .rem_gt_page_o(c_gt),
    .ptr_aligned_o(c_aligned),
    .ptr_ok_o     (c_ok)
  );

  assign ld_len = (state_q == ST_FIRST) ? c_first : c_page_len;

  plw_seg_slot #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_slot (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (seg_load),
    .addr_i (calc_ptr),
    .len_i  (ld_len),
    .free_o (seg_free),
    .valid_o(seg_valid_o),
    .ready_i(seg_ready_i),
    .addr_o (seg_addr_o),
    .len_o  (seg_len_o)
  );

  plw_list_track #(.CNT_W(CNT_W)) u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (trk_load),
    .cnt_i  (c_req),
    .beat_i (trk_beat),
    .slot_o (slot),
    .beats_o(beats)
  );

  assign cmd_ready_o    = (state_q == ST_IDLE);
  assign rd_req_valid_o = (state_q == ST_REQ);
  assign rd_req_addr_o  = list_q;
  assign rd_req_cnt_o   = c_req;
  assign ent_ready_o    = ((state_q == ST_ENTRY) && seg_free) || (state_q == ST_DRAIN);
  assign ent_beat       = ent_valid_i && ent_ready_o;
  assign is_chain       = (slot == c_epp_m1) && c_gt;
  assign last_beat      = (beats == CNT_W'(1));
  assign walk_done_o    = done_q;
  assign walk_err_o     = fail_q;

  always_comb begin
    state_d  = state_q;
    seg_load = 1'b0;
    trk_load = 1'b0;
    trk_beat = 1'b0;
    case (state_q)
      ST_IDLE:
        if (cmd_valid_i && cmd_len_i != '0) state_d = ST_FIRST;
      ST_FIRST:
        if (seg_free) begin
          seg_load = 1'b1;
          state_d  = ST_ROUTE;
        end
      ST_ROUTE:
        if (rem_q == '0)  state_d = ST_FLUSH;
        else if (!c_gt)   state_d = ST_DIRECT;
        else              state_d = ST_REQ;
      ST_DIRECT:
        if (!c_aligned) state_d = ST_FLUSH;
        else if (seg_free) begin
          seg_load = 1'b1;
          state_d  = ST_FLUSH;
        end
      ST_REQ:
        if (rd_req_ready_i) begin
          trk_load = 1'b1;
          state_d  = ST_ENTRY;
        end
      ST_ENTRY:
        if (ent_beat) begin
          trk_beat = 1'b1;
          if (!c_ok)          state_d = last_beat ? ST_FLUSH : ST_DRAIN;
          else if (is_chain)  state_d = ST_REQ;
          else begin
            seg_load = 1'b1;
            if (!c_gt) state_d = ST_FLUSH;
          end
        end
      ST_DRAIN:
        if (ent_beat) begin
          trk_beat = 1'b1;
          if (last_beat) state_d = ST_FLUSH;
        end
      ST_FLUSH:
        if (!seg_valid_o) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shift_q <= '0;
      rem_q   <= '0;
      p1_q    <= '0;
      list_q  <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      case (state_q)
        ST_IDLE:
          if (cmd_valid_i) begin
            shift_q <= page_shift_i;
            rem_q   <= cmd_len_i;
            p1_q    <= cmd_ptr1_i;
            list_q  <= cmd_ptr2_i;
            err_q   <= 1'b0;
            if (cmd_len_i == '0) done_q <= 1'b1;
          end
        ST_FIRST:
          if (seg_free) rem_q <= rem_q - c_first;
        ST_DIRECT:
          if (!c_aligned)    err_q <= 1'b1;
          else if (seg_free) rem_q <= '0;
        ST_ENTRY:
          if (ent_beat) begin
            if (!c_ok)         err_q  <= 1'b1;
            else if (is_chain) list_q <= ADDR_W'(ent_data_i);
            else               rem_q  <= rem_q - c_page_len;
          end
        ST_FLUSH:
          if (!seg_valid_o) begin
            done_q <= !err_q;
            fail_q <= err_q;
          end
        default: ;
      endcase
    end
  end

  a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({walk_done_o, walk_err_o}));

  a_r9_end_after_last_seg: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done_o || walk_err_o) |-> !seg_valid_o && !rd_req_valid_o);

  a_r1_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_ready_o && cmd_len_i == '0) |=> walk_done_o && !seg_valid_o);

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid_o && !rd_req_ready_i |=>
      rd_req_valid_o && $stable(rd_req_addr_o) && $stable(rd_req_cnt_o));

  a_r5_seg_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid_o |-> seg_len_o != '0);

endmodule

// File: tb/page_list_walker_test.sv
module page_list_walker_test;

  localparam int SW = 4;
  localparam int CW = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0, cmd_ready;
  logic [31:0]   cmd_len = '0;
  logic [63:0]   cmd_ptr1 = '0, cmd_ptr2 = '0;
  logic [SW-1:0] page_shift = '0;
  logic          seg_valid, seg_ready = 1'b0;
  logic [63:0]   seg_addr;
  logic [31:0]   seg_len;
  logic          rd_req_valid, rd_req_ready = 1'b0;
  logic [63:0]   rd_req_addr;
  logic [CW-1:0] rd_req_cnt;
  logic          ent_valid = 1'b0, ent_ready;
  logic [63:0]   ent_data = '0;
  logic          walk_done, walk_err;

  page_list_walker uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_len_i(cmd_len),
    .cmd_ptr1_i(cmd_ptr1), .cmd_ptr2_i(cmd_ptr2), .page_shift_i(page_shift),
    .seg_valid_o(seg_valid), .seg_ready_i(seg_ready), .seg_addr_o(seg_addr), .seg_len_o(seg_len),
    .rd_req_valid_o(rd_req_valid), .rd_req_ready_i(rd_req_ready),
    .rd_req_addr_o(rd_req_addr), .rd_req_cnt_o(rd_req_cnt),
    .ent_valid_i(ent_valid), .ent_ready_o(ent_ready), .ent_data_i(ent_data),
    .walk_done_o(walk_done), .walk_err_o(walk_err)
  );

  int n_chk = 0, n_bad = 0, all_cyc = 0;
  logic [63:0] e_addr [0:255];
  longint      e_len  [0:255];
  int          e_n;
  logic [63:0] r_addr [0:63];
  longint      r_cnt  [0:63];
  int          r_n;
  bit          e_err;
  logic [63:0] bq [0:255];
  int          bq_wr, bq_rd;
  logic [15:0] lf = 16'hACE1;
  logic [63:0] cur_badw;
  int          cur_kind;
  localparam logic [63:0] NONE = 64'hFFFF_FFFF_FFFF_FFFF;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // list memory: every entry is a page-aligned nonzero pointer unless poisoned
  function automatic logic [63:0] memw(input logic [63:0] a, input logic [63:0] badw, input int kind);
    if (a == badw) return (kind == 0) ? 64'h0 : ((((a >> 3) + 64'd1) << 12) + 64'h8);
    return ((a >> 3) + 64'd1) << 12;
  endfunction

  task automatic model(input int sh_in, input longint len, input logic [63:0] p1, p2);
    int esh;
    longint pg, epp, first, rem, pages, cnt, seg;
    logic [63:0] lst, v;
    bit fin;
    esh = (sh_in < 4) ? 4 : (sh_in > 12) ? 12 : sh_in;   // R10 clamp
    pg = 64'd1 << esh; epp = pg / 8;
    e_n = 0; r_n = 0; e_err = 0;
    if (len == 0) return;
    first = pg - longint'(p1 % pg);
    if (len < first) first = len;
    e_addr[e_n] = p1; e_len[e_n] = first; e_n++;
    rem = len - first;
    if (rem == 0) return;
    if (rem <= pg) begin
      if ((p2 % pg) != 0) e_err = 1;
      else begin e_addr[e_n] = p2; e_len[e_n] = rem; e_n++; end
      return;
    end
    lst = p2; fin = 0;
    while (!fin) begin
      pages = (rem + pg - 1) / pg;
      cnt = (pages < epp) ? pages : epp;
      r_addr[r_n] = lst; r_cnt[r_n] = cnt; r_n++;
      for (int i = 0; i < cnt; i++) begin
        v = memw(lst + 64'(8 * i), cur_badw, cur_kind);
        if (v == 0 || (v % pg) != 0) begin e_err = 1; fin = 1; break; end
        if (i == epp - 1 && rem > pg) begin lst = v; break; end
        seg = (rem < pg) ? rem : pg;
        e_addr[e_n] = v; e_len[e_n] = seg; e_n++;
        rem -= seg;
        if (rem == 0) begin fin = 1; break; end
      end
    end
  endtask

  task automatic walk(input int sh_in, input longint len, input logic [63:0] p1, p2,
                      input logic [63:0] badw, input int kind, input string ovr);
    int got, rq, cyc;
    bit fin, clr, hold, saw_err;
    logic [63:0] h_addr, h_len;
    string tg;
    cur_badw = badw; cur_kind = kind;
    model(sh_in, len, p1, p2);
    if (ovr != "")     tg = ovr;
    else if (len == 0) tg = "R1";
    else if (r_n > 1)  tg = "R6";
    else if (r_n == 1) tg = "R5";
    else if (e_n == 2) tg = "R3";
    else               tg = "R2";
    bq_wr = 0; bq_rd = 0;
    got = 0; rq = 0; cyc = 0; fin = 0; hold = 0; saw_err = 0;
    @(negedge clk);
    page_shift = SW'(sh_in); cmd_len = 32'(len); cmd_ptr1 = p1; cmd_ptr2 = p2; cmd_valid = 1'b1;
    while (!fin && cyc < 5000) begin
      if (walk_done || walk_err) begin fin = 1; saw_err = walk_err; break; end
      if (hold) begin
        chk(seg_valid && seg_addr == h_addr && 64'(seg_len) == h_len, "R8", "held segment",
            {seg_addr[31:0], seg_len}, {h_addr[31:0], h_len[31:0]});
      end
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      seg_ready    = lf[0] | lf[3];
      rd_req_ready = lf[1] | lf[5];
      ent_valid    = (bq_rd < bq_wr) && (lf[2] | lf[6]);
      ent_data     = (bq_rd < bq_wr) ? bq[bq_rd] : 64'h0;
      #1;
      clr = cmd_valid && cmd_ready;
      hold = seg_valid && !seg_ready;
      h_addr = seg_addr; h_len = 64'(seg_len);
      if (seg_valid && seg_ready) begin
        if (got < e_n) begin
          chk(seg_addr == e_addr[got], (got == 0) ? "R2" : tg, "segment address", seg_addr, e_addr[got]);
          chk(64'(seg_len) == 64'(e_len[got]), (got == 0) ? "R2" : tg, "segment length",
              64'(seg_len), 64'(e_len[got]));
        end else chk(0, tg, "unexpected segment", seg_addr, 64'h0);
        got++;
      end
      if (rd_req_valid && rd_req_ready) begin
        if (rq < r_n) begin
          chk(rd_req_addr == r_addr[rq], "R4", "request address", rd_req_addr, r_addr[rq]);
          chk(64'(rd_req_cnt) == 64'(r_cnt[rq]), "R4", "request count", 64'(rd_req_cnt), 64'(r_cnt[rq]));
        end else chk(0, "R6", "unexpected request", rd_req_addr, 64'h0);
        for (int i = 0; i < int'(rd_req_cnt); i++) begin
          bq[bq_wr] = memw(rd_req_addr + 64'(8 * i), cur_badw, cur_kind);
          bq_wr++;
        end
        rq++;
      end
      if (ent_valid && ent_ready) bq_rd++;
      @(negedge clk);
      if (clr) cmd_valid = 1'b0;
      cyc++;
    end
    cmd_valid = 1'b0;
    chk(fin, tg, "walk finished (timeout)", 64'(cyc), 64'd5000);
    chk(got == e_n, tg, "segment count", 64'(got), 64'(e_n));
    chk(rq == r_n, "R4", "request count total", 64'(rq), 64'(r_n));
    chk(saw_err == e_err, e_err ? "R7" : tg, "error outcome", 64'(saw_err), 64'(e_err));
    chk(bq_rd == bq_wr, "R7", "unconsumed beats", 64'(bq_wr - bq_rd), 64'h0);
    seg_ready = 1'b0; rd_req_ready = 1'b0; ent_valid = 1'b0;
    @(negedge clk);
    chk(!walk_done && !walk_err, "R9", "pulse width", {62'h0, walk_done, walk_err}, 64'h0);
  endtask

  always @(posedge clk) begin
    all_cyc++;
    if (all_cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog actual=%0d expected=<190000", all_cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(cmd_ready, "R9", "reset cmd_ready", 64'(cmd_ready), 64'd1);
    chk(!seg_valid && !rd_req_valid, "R9", "reset valids", {62'h0, seg_valid, rd_req_valid}, 64'h0);
    chk(!walk_done && !walk_err, "R9", "reset pulses", {62'h0, walk_done, walk_err}, 64'h0);

    // sweep: page size, first-pointer offset, length
    for (int sh = 4; sh <= 6; sh++) begin
      for (int oi = 0; oi < 4; oi++) begin
        for (int k = 0; k <= 16; k++) begin
          longint pg, epp, off, len;
          pg = 64'd1 << sh; epp = pg / 8;
          off = (oi == 0) ? 0 : (oi == 1) ? 8 : (oi == 2) ? pg - 8 : 3;
          len = (k * pg * (epp + 3)) / 16 + (k % 3);
          walk(sh, len, 64'h5000_0000 + 64'(off), 64'h0001_0000, NONE, 0, "");
        end
      end
    end

    // R7: poisoned entries in the first list page (data slot and chain slot)
    for (int j = 0; j < 2; j++) begin
      for (int kd = 0; kd < 2; kd++) begin
        walk(4, 112, 64'h5000_0000, 64'h0001_0000, 64'h0001_0000 + 64'(8 * j), kd, "R7");
      end
    end
    // R7: poisoned entry inside a chained list page
    for (int kd = 0; kd < 2; kd++) begin
      walk(4, 112, 64'h5000_0000, 64'h0001_0000, memw(64'h0001_0008, NONE, 0), kd, "R7");
    end
    // R7: mid-list failure leaves beats to drain
    walk(5, 32 * 9, 64'h5000_0000, 64'h0001_0000, 64'h0001_0008, 1, "R7");
    // R3: misaligned direct second pointer, and zero direct pointer accepted
    walk(4, 20, 64'h5000_0000, 64'h0002_0008, NONE, 0, "R3");
    walk(4, 20, 64'h5000_0004, 64'h0, NONE, 0, "R3");
    // R10: shift clamped at both ends
    walk(2, 100, 64'h5000_0004, 64'h0001_0000, NONE, 0, "R10");
    walk(15, 5000, 64'h5000_0010, 64'h0001_0000, NONE, 0, "R10");
    // R1: zero length
    walk(6, 0, 64'h5000_0000, 64'h0001_0000, NONE, 0, "R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule